// File: doc/BRIEF.md
# Streaming Sobel Edge Map Generator

This block turns a raster-ordered stream of 8-bit grayscale pixels into a binary edge map of the same size and order. Two single-line stores hold the rows above the current one. Together with the incoming pixel they feed a 3x3 sliding window. For every pixel of the frame interior the block forms a horizontal and a vertical Sobel gradient. It adds their squares and outputs 255 when that sum exceeds a programmable threshold, and 0 otherwise.

Pixels on the outermost ring of the frame are always output as 0. Each output pixel therefore maps one-to-one onto an input pixel. Frame height and width are taken from input ports, so each frame can use different dimensions. A start-of-frame flag on the first pixel re-aligns the internal raster position.

Both streams use a valid/ready handshake. The output trails the input by one row plus one pixel. After the last pixel of a frame, the block drains the remaining outputs on its own and refuses new input while it does so. Backpressure on the output freezes the whole pipeline.

Top module: `sobel_edge_stream`

## Requirements
- R1: The horizontal gradient of the window centred on pixel (r,c) is [p(r-1,c+1) + 2*p(r,c+1) + p(r+1,c+1)] minus [p(r-1,c-1) + 2*p(r,c-1) + p(r+1,c-1)].
- R2: The vertical gradient is [p(r-1,c-1) + 2*p(r-1,c) + p(r-1,c+1)] minus [p(r+1,c-1) + 2*p(r+1,c) + p(r+1,c+1)].
- R3: An interior output pixel is 255 when gx*gx + gy*gy is strictly greater than `edge_thresh`, and 0 otherwise, including when the two are equal. No square root is taken.
- R4: Every output pixel in row 0, row rows-1, column 0 or column cols-1 is 0.
- R5: A frame of rows*cols input pixels yields exactly rows*cols output pixels in the same raster order. After reset `out_valid` is 0 and `in_ready` is 1.
- R6: The first output pixel of a frame becomes valid only after cols+2 input pixels have been accepted. After the last input pixel is accepted, with `out_ready` held high, `in_ready` stays low for exactly cols+1 cycles while the remaining outputs drain.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. Stalls and input gaps never drop or duplicate a pixel.
- R8: An accepted pixel with `in_sof` high is treated as pixel (0,0) of a new frame, whatever position the previous frame had reached.
- R9: `frame_rows` (3 or more) and `frame_cols` (3 up to MAX_COLS) may differ from frame to frame, and each frame is processed with its own dimensions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_rows | input | DIM_W | Frame height in pixels, stable during a frame |
| frame_cols | input | DIM_W | Frame width in pixels, stable during a frame |
| edge_thresh | input | 21 | Threshold for the squared gradient magnitude |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts the input pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_data | input | 8 | Grayscale input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | 8 | Edge map pixel, 255 or 0 |

## Verification
The main function is exercised with several images, each separating a different part of the computation:
- A flat image must give no edges even at threshold zero.
- A vertical step creates a purely horizontal gradient, which isolates gx.
- A horizontal step isolates gy.
- Run at a threshold equal to the step's known magnitude and one below it, the vertical step separates strict from non-strict comparison.
- Hashed and ramp textures mix both gradients across the full range of signs.

Frames of minimum size, of maximum width and of mixed shapes, some under random-looking output stalls and input gaps, show that dimensions, border handling, latency, flushing and restart on a start-of-frame flag all behave as required.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W  = 8;
    localparam int GRAD_W = 11;
    localparam int MAG_W  = 21;
    localparam int WIN_N  = 3;

    typedef logic [PIX_W-1:0]          pix_t;
    typedef logic signed [GRAD_W-1:0]  grad_t;
    typedef logic [MAG_W-1:0]          mag_t;
    // one window column, index 0 = top row, 2 = bottom row
    typedef pix_t [WIN_N-1:0]          col_t;
    // whole window, index 0 = left column, 2 = right column
    typedef col_t [WIN_N-1:0]          win_t;

    localparam pix_t EDGE_ON  = pix_t'(255);
    localparam pix_t EDGE_OFF = pix_t'(0);

    // weighted sum of one column, weights 1-2-1 top to bottom
    function automatic int col_weight(input col_t c);
        return int'(c[0]) + 2 * int'(c[1]) + int'(c[2]);
    endfunction

    // right column minus left column
    function automatic grad_t grad_horiz(input win_t w);
        return grad_t'(col_weight(w[2]) - col_weight(w[0]));
    endfunction

    // top row minus bottom row, weights 1-2-1 left to right
    function automatic grad_t grad_vert(input win_t w);
        int top_s;
        int bot_s;
        top_s = int'(w[0][0]) + 2 * int'(w[1][0]) + int'(w[2][0]);
        bot_s = int'(w[0][2]) + 2 * int'(w[1][2]) + int'(w[2][2]);
        return grad_t'(top_s - bot_s);
    endfunction

    function automatic mag_t mag_sq(input grad_t a, input grad_t b);
        int ia;
        int ib;
        ia = int'(a);
        ib = int'(b);
        return mag_t'(ia * ia + ib * ib);
    endfunction

endpackage

// File: rtl/sobel_line_buf.sv
module sobel_line_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem_q [DEPTH];

    // read the old value at the address that is about to be overwritten
    always_comb begin
        rd_data = mem_q[addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= wr_data;
        end
    end

    // R9
    lb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(addr)] == $past(wr_data)));

endmodule

// File: rtl/sobel_window.sv
module sobel_window
    import sobel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  col_t  col_in,
    output grad_t gx,
    output grad_t gy
);

    typedef struct packed {
        win_t win;
    } win_st_t;

    win_st_t s_d;
    win_st_t s_q;

    always_comb begin
        s_d = s_q;
        if (step) begin
            s_d.win[0] = s_q.win[1];
            s_d.win[1] = s_q.win[2];
            s_d.win[2] = col_in;
        end
        // gradients of the window as it stands after this step
        gx = grad_horiz(s_d.win);
        gy = grad_vert(s_d.win);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(s_q.win));

endmodule

// File: rtl/sobel_raster_ctrl.sv
module sobel_raster_ctrl #(
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             sof_fire,
    input  logic [DIM_W-1:0] rows_i,
    input  logic [DIM_W-1:0] cols_i,
    output logic [DIM_W-1:0] col_idx,
    output logic             flushing,
    output logic             emit,
    output logic             interior
);

    localparam int RW = DIM_W + 1;

    typedef struct packed {
        logic [RW-1:0]    prow;   // raster row of the next step
        logic [DIM_W-1:0] pcol;   // raster column of the next step
        logic [DIM_W-1:0] orow;   // row of the next output pixel
        logic [DIM_W-1:0] ocol;   // column of the next output pixel
        logic             on;     // output side has started
    } ctrl_st_t;

    ctrl_st_t s_d;
    ctrl_st_t s_q;

    logic [RW-1:0]    erow;
    logic [DIM_W-1:0] ecol;
    logic             eon;
    logic [DIM_W-1:0] col_last;
    logic [DIM_W-1:0] row_last;
    logic [RW-1:0]    row_done;

    always_comb begin
        col_last = cols_i - DIM_W'(1);
        row_last = rows_i - DIM_W'(1);
        row_done = RW'(rows_i) + RW'(1);

        // a start-of-frame pixel is always position (0,0)
        erow = sof_fire ? '0   : s_q.prow;
        ecol = sof_fire ? '0   : s_q.pcol;
        eon  = sof_fire ? 1'b0 : s_q.on;

        s_d = s_q;
        if (step) begin
            s_d.on = eon;
            if (ecol == col_last) begin
                s_d.pcol = '0;
                s_d.prow = erow + RW'(1);
            end else begin
                s_d.pcol = ecol + DIM_W'(1);
                s_d.prow = erow;
            end

            if (eon) begin
                if (s_q.ocol == col_last) begin
                    s_d.ocol = '0;
                    s_d.orow = s_q.orow + DIM_W'(1);
                end else begin
                    s_d.ocol = s_q.ocol + DIM_W'(1);
                end
            end

            // one row plus one pixel seen: outputs start with the next step
            if (erow == RW'(1) && ecol == '0) begin
                s_d.on   = 1'b1;
                s_d.orow = '0;
                s_d.ocol = '0;
            end

            // final flush step of the frame
            if (erow == row_done) begin
                s_d = '0;
            end
        end

        col_idx  = ecol;
        flushing = (s_q.prow >= RW'(rows_i));
        emit     = step && eon;
        interior = (s_q.orow != '0) && (s_q.orow != row_last) &&
                   (s_q.ocol != '0) && (s_q.ocol != col_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sof_fire && cols_i > DIM_W'(1)) |=>
            (s_q.prow == '0 && s_q.pcol == DIM_W'(1) && !s_q.on));

    // R9
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cols_i != '0) |-> (s_q.pcol < cols_i));

endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
    import sobel_pkg::*;
#(
    parameter int MAX_COLS = 64,
    parameter int DIM_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIM_W-1:0] frame_rows,
    input  logic [DIM_W-1:0] frame_cols,
    input  logic [20:0]      edge_thresh,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data
);

    localparam int NUM_LINES = WIN_N - 1;
    localparam int AW        = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;

    typedef struct packed {
        logic valid;
        pix_t data;
    } out_st_t;

    out_st_t s_d;
    out_st_t s_q;

    logic             adv;
    logic             in_fire;
    logic             step;
    logic             sof_fire;
    logic             flushing;
    logic             emit;
    logic             interior;
    logic [DIM_W-1:0] col_idx;
    pix_t             pix_in;
    col_t             col_in;
    grad_t            gx;
    grad_t            gy;
    mag_t             mag;

    pix_t lb_in  [NUM_LINES];
    pix_t lb_out [NUM_LINES];

    always_comb begin
        adv      = !s_q.valid || out_ready;
        in_ready = adv && !flushing;
        in_fire  = in_valid && in_ready;
        step     = in_fire || (adv && flushing);
        sof_fire = in_fire && in_sof;
        pix_in   = flushing ? '0 : in_data;
    end

    sobel_raster_ctrl #(.DIM_W(DIM_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .sof_fire (sof_fire),
        .rows_i   (frame_rows),
        .cols_i   (frame_cols),
        .col_idx  (col_idx),
        .flushing (flushing),
        .emit     (emit),
        .interior (interior)
    );

    // cascade of line stores: line 0 holds the row above, line 1 two rows above
    for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
        if (li == 0) begin : g_first
            assign lb_in[li] = pix_in;
        end else begin : g_next
            assign lb_in[li] = lb_out[li-1];
        end
        sobel_line_buf #(.DEPTH(MAX_COLS), .W(PIX_W), .AW(AW)) u_lb (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (step),
            .addr    (AW'(col_idx)),
            .wr_data (lb_in[li]),
            .rd_data (lb_out[li])
        );
    end

    always_comb begin
        col_in[WIN_N-1] = pix_in;
        for (int k = 0; k < NUM_LINES; k++) begin
            col_in[WIN_N-2-k] = lb_out[k];
        end
    end

    sobel_window u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .col_in (col_in),
        .gx     (gx),
        .gy     (gy)
    );

    always_comb begin
        mag = mag_sq(gx, gy);
        s_d = s_q;
        if (step) begin
            s_d.valid = emit;
            s_d.data  = (interior && (mag > mag_t'(edge_thresh))) ? EDGE_ON : EDGE_OFF;
        end else if (out_ready) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_data  = s_q.data;

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/sobel_edge_stream_tb.sv
`timescale 1ns/1ps
module sobel_edge_stream_tb;

    localparam int TB_MAXC = 16;
    localparam int NV      = 9;
    localparam int NF      = 6;
    // rows, cols, pattern, threshold, stall, requirement tag
    localparam int VEC [NV][NF] = '{
        '{5,  6,  0, 0,       0, 3},   // R3 flat image
        '{6,  8,  1, 39999,   0, 1},   // R1 vertical step, just below
        '{6,  8,  1, 40000,   0, 3},   // R3 equal threshold gives 0
        '{7,  5,  2, 39999,   0, 2},   // R2 horizontal step
        '{8,  10, 3, 50000,   1, 7},   // R7 hashed under stalls
        '{3,  3,  3, 1000,    0, 9},   // R9 minimum frame
        '{9,  16, 4, 20000,   1, 9},   // R9 maximum width
        '{4,  12, 3, 0,       0, 5},   // R5 mixed shape
        '{5,  7,  3, 2097151, 0, 3}    // R3 saturated threshold
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  frame_rows = 8'd5;
    logic [7:0]  frame_cols = 8'd6;
    logic [20:0] edge_thresh = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    int got_pix [256];
    int first_at;
    int low_cnt;
    int hold_bad;

    always #10 clk = ~clk;

    sobel_edge_stream #(.MAX_COLS(TB_MAXC), .DIM_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_rows(frame_rows), .frame_cols(frame_cols),
        .edge_thresh(edge_thresh), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int pix(input int pat, input int r, input int c);
        case (pat)
            0: return 100;
            1: return (c >= 3) ? 60 : 10;
            2: return (r >= 3) ? 60 : 10;
            3: return ((r * 37 + c * 91 + r * c * 13) ^ (r << 3)) & 255;
            default: return (r * 20 + c * 9) & 255;
        endcase
    endfunction

    function automatic int expect_pix(input int pat, input int rows, input int cols,
                                      input int thr, input int r, input int c);
        int gx;
        int gy;
        int m;
        if (r == 0 || c == 0 || r == rows - 1 || c == cols - 1) return 0;
        gx = (pix(pat, r-1, c+1) + 2 * pix(pat, r, c+1) + pix(pat, r+1, c+1))
           - (pix(pat, r-1, c-1) + 2 * pix(pat, r, c-1) + pix(pat, r+1, c-1));
        gy = (pix(pat, r-1, c-1) + 2 * pix(pat, r-1, c) + pix(pat, r-1, c+1))
           - (pix(pat, r+1, c-1) + 2 * pix(pat, r+1, c) + pix(pat, r+1, c+1));
        m = gx * gx + gy * gy;
        return (m > thr) ? 255 : 0;
    endfunction

    task automatic run_frame(input int rows, input int cols, input int pat,
                             input int thr, input int stall, input int tag);
        int total;
        int sent;
        int got;
        int cyc;
        bit pv;
        bit pr;
        int pd;
        string ts;
        total = rows * cols;
        sent = 0; got = 0; cyc = 0;
        first_at = -1; low_cnt = 0; hold_bad = 0;
        pv = 1'b0; pr = 1'b0; pd = 0;
        frame_rows = 8'(rows);
        frame_cols = 8'(cols);
        edge_thresh = 21'(thr);
        while ((got < total || sent < total) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            out_ready = (stall != 0) ? (((cyc * 7) % 5) < 3) : 1'b1;
            in_valid  = (sent < total) && !((stall != 0) && (cyc % 4 == 1));
            in_data   = (sent < total) ? 8'(pix(pat, sent / cols, sent % cols)) : 8'd0;
            in_sof    = (sent == 0);
            #2;
            if (pv && !pr && !(out_valid && int'(out_data) == pd)) hold_bad++;
            pv = out_valid; pr = out_ready; pd = int'(out_data);
            if (out_valid && out_ready) begin
                if (first_at < 0) first_at = sent;
                if (got < 256) got_pix[got] = int'(out_data);
                got++;
            end
            if (in_valid && in_ready) sent++;
            else if (sent == total && !in_ready) low_cnt++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1;
        ts = $sformatf("R%0d", tag);
        // R5 count of output pixels
        check("R5", got, total, "output pixel count");
        for (int i = 0; i < total && i < 256; i++) begin
            int r;
            int c;
            r = i / cols;
            c = i % cols;
            if (r == 0 || c == 0 || r == rows - 1 || c == cols - 1)
                check("R4", got_pix[i], 0, $sformatf("border pixel %0d,%0d", r, c));
            else
                check(ts, got_pix[i], expect_pix(pat, rows, cols, thr, r, c),
                      $sformatf("pixel %0d,%0d", r, c));
        end
        if (stall != 0) check("R7", hold_bad, 0, "stalled output changed");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R5 reset state
        check("R5", int'(out_valid), 0, "out_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check("R5", int'(out_valid), 0, "out_valid after reset");
        check("R5", int'(in_ready), 1, "in_ready after reset");

        for (int v = 0; v < NV; v++) begin
            run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            if (v == 1) begin
                // R6 latency and flush length
                check("R6", first_at, VEC[v][1] + 2, "inputs accepted before first output");
                check("R6", low_cnt, VEC[v][1] + 1, "flush cycles with in_ready low");
            end
        end

        // R8 abandoned partial frame, then a full frame restarted by the flag
        frame_rows = 8'd5;
        frame_cols = 8'd6;
        edge_thresh = 21'd3000;
        begin
            int seen;
            seen = 0;
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sof = (p == 0);
                in_data = 8'(p * 50 + 7);
                #2;
                if (out_valid) seen++;
            end
            @(negedge clk);
            in_valid = 1'b0;
            in_sof = 1'b0;
            #2;
            if (out_valid) seen++;
            check("R8", seen, 0, "outputs from a short partial frame");
        end
        run_frame(5, 6, 3, 3000, 0, 8);
        // R8 restart again with a different pattern
        run_frame(6, 7, 4, 500, 1, 8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule